// File: doc/BRIEF.md
# Serial bit-clock and frame-sync generator

This block derives the bit clock of a synchronous audio serial port from a faster input clock, together with a one-cycle strobe per bit and a periodic frame-sync signal. A programmable divider, written as the ratio minus one, sets the bit rate. The ratio is picked so that the input clock divided by it equals the frame rate times the number of bit clocks per frame.

A frame counter steps once per bit strobe and wraps after a programmable period, also written as count minus one: a value of 31 gives a 32-bit stereo frame and 255 gives a 256-bit frame. Frame sync is active for a programmable width at the head of every frame. A width of 15 in a 32-bit frame gives a half-frame left/right select, and a width of 0 gives a single-bit pulse. Sync polarity is selectable: active-low suits the left/right stereo format and active-high suits short-pulse PCM.

Clocking and framing have separate enables. The bit clock can therefore run before framing starts. The divider may only be changed while the clock generator is off. Width and period changes are picked up at the next frame boundary.

Top module: `sclk_fsync_gen`

## Requirements
- R1: During reset, bit_stb and bclk are 0 and fsync sits at its inactive level, which is the inverse of sync_act_hi.
- R2: With gen_en held high and div_val = D captured, bit_stb is high for one input cycle out of every D+1. The first strobe follows D+1 rising edges after gen_en is first sampled high. For D > 0, bclk goes high with each strobe and goes low at the edge where the phase count equals D/2 (integer halving).
- R3: With a divider value of 0, bit_stb is high on every input cycle and bclk follows the input clock.
- R4: The divider value is captured only while gen_en is low. Changing div_val while gen_en is high does not alter the strobe spacing.
- R5: A frame lasts per_val+1 bit strobes. The period value in force is captured at the first strobe of each frame.
- R6: fsync is active during the first wid_val+1 strobes of each frame and inactive for the rest. A value of 0 gives a one-strobe pulse. A width at or above the period keeps sync active for the whole frame.
- R7: Framing starts at the first strobe after frame_en is sampled high. That strobe is position 0 and activates sync. While frame_en is low, strobes still run and sync stays inactive.
- R8: Changes to wid_val or per_val in the middle of a frame take effect only at the next frame boundary.
- R9: With sync_act_hi = 1, the active sync level is high. With sync_act_hi = 0, the active level is low, as used for left/right stereo framing.
- R10: One edge after gen_en is sampled low, bit_stb and bclk are 0. One edge after frame_en is sampled low, fsync is inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Bit-clock generator enable |
| frame_en | input | 1 | Frame-generation enable |
| div_val | input | DIV_W | Divide ratio minus one |
| per_val | input | FRM_W | Bit strobes per frame minus one |
| wid_val | input | FRM_W | Sync-active strobes minus one |
| sync_act_hi | input | 1 | 1: sync active high, 0: active low |
| bclk | output | 1 | Bit clock |
| bit_stb | output | 1 | One-input-cycle strobe per bit |
| fsync | output | 1 | Frame sync |

## Verification
Every output is a register stage, apart from the polarity select and the ratio-one clock path. A result caused by inputs sampled at a rising edge is therefore visible in the cycle after that edge. The first strobe after enabling with divider D lands in cycle D, counting the cycle after the enabling edge as 0. Sync changes in the same cycle as the strobe that moves the frame position. Disabling shows at the outputs one edge later.

The driver task computes, from those rules, the expected {bit_stb, bclk, fsync} for every cycle of a case. This includes mid-run changes to divider, width and period, and a delayed frame enable. The driver queues the values before applying the first input. The monitor pops one entry a quarter period after each rising edge, so each comparison lands in exactly the cycle its result is due.

// File: rtl/sclk_fsync_gen.sv
module sclk_fsync_gen #(
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             frame_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic [FRM_W-1:0] per_val,
  input  logic [FRM_W-1:0] wid_val,
  input  logic             sync_act_hi,
  output logic             bclk,
  output logic             bit_stb,
  output logic             fsync
);

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
  localparam logic [FRM_W-1:0] FRM_ONE = FRM_W'(1);

  logic [DIV_W-1:0] div_q, cnt;
  logic             tick, bclk_q;
  logic [FRM_W-1:0] per_q, wid_q, pos, pos_nx;
  logic             run, fs_q;

  assign tick   = gen_en && (cnt == div_q);
  assign pos_nx = pos + FRM_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt     <= '0;
      bit_stb <= 1'b0;
      bclk_q  <= 1'b0;
    end else if (!gen_en) begin
      div_q   <= div_val;
      cnt     <= '0;
      bit_stb <= 1'b0;
      bclk_q  <= 1'b0;
    end else begin
      bit_stb <= tick;
      cnt     <= tick ? '0 : cnt + DIV_ONE;
      if (tick)
        bclk_q <= 1'b1;
      else if (cnt == (div_q >> 1))
        bclk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      pos   <= '0;
      per_q <= '0;
      wid_q <= '0;
      fs_q  <= 1'b0;
    end else if (!frame_en) begin
      run  <= 1'b0;
      pos  <= '0;
      fs_q <= 1'b0;
    end else if (tick) begin
      if (!run || pos == per_q) begin
        run   <= 1'b1;
        pos   <= '0;
        per_q <= per_val;
        wid_q <= wid_val;
        fs_q  <= 1'b1;
      end else begin
        pos  <= pos_nx;
        fs_q <= (pos_nx <= wid_q);
      end
    end
  end

  assign bclk  = (div_q == '0) ? (clk & gen_en) : bclk_q;
  assign fsync = fs_q ? sync_act_hi : !sync_act_hi;

endmodule

// File: rtl/sclk_fsync_gen_chk.sv
module sclk_fsync_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             frame_en,
  input logic             sync_act_hi,
  input logic             bit_stb,
  input logic             fsync,
  input logic [DIV_W-1:0] div_q,
  input logic             tick,
  input logic             fs_q
);

  // R10
  gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !bit_stb);

  // R10
  frame_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> (fsync != sync_act_hi));

  // R6
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && !tick) |=> $stable(fs_q));

  // R2
  stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && gen_en && div_q != '0) |=> !bit_stb);

  // R3
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gen_en) && $past(div_q) == '0) |-> bit_stb);

endmodule

bind sclk_fsync_gen sclk_fsync_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .frame_en(frame_en),
  .sync_act_hi(sync_act_hi), .bit_stb(bit_stb), .fsync(fsync),
  .div_q(div_q), .tick(tick), .fs_q(fs_q)
);

// File: tb/test_sclk_fsync_gen.sv
module test_sclk_fsync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_en = 1'b0, frame_en = 1'b0, sync_act_hi = 1'b1;
  logic [DW-1:0] div_val = '0;
  logic [FW-1:0] per_val = '0, wid_val = '0;
  logic bclk, bit_stb, fsync;

  int total = 0, bad = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_fsync_gen #(.DIV_W(DW), .FRM_W(FW)) i_sclk_fsync_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .frame_en(frame_en),
    .div_val(div_val), .per_val(per_val), .wid_val(wid_val),
    .sync_act_hi(sync_act_hi), .bclk(bclk), .bit_stb(bit_stb), .fsync(fsync)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s {stb,bclk,fs} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {bit_stb, bclk, fsync}, e);
    end
  end

  task automatic run_case(input string req, input int d, input int d2,
                          input int p, input int w, input int p2, input int w2,
                          input int cc, input int fd, input logic pol, input int n);
    bit run = 0;
    int pos = 0, cp = 0, cw = 0;
    bit act = 0;
    @(negedge clk);
    gen_en = 0; frame_en = 0; sync_act_hi = pol;
    div_val = DW'(d); per_val = FW'(p); wid_val = FW'(w);
    @(negedge clk);
    for (int c = 0; c < n; c++) begin
      int ph;
      bit tk, bc;
      ph = c % (d + 1);
      tk = (ph == d);
      if (d == 0) bc = 1;
      else if (tk) bc = 1;
      else if (ph >= (d >> 1)) bc = 0;
      else bc = (c >= d);
      if (c < fd) begin
        run = 0; act = 0;
      end else if (tk) begin
        if (!run || pos == cp) begin
          run = 1; pos = 0;
          cp = (c >= cc) ? p2 : p;
          cw = (c >= cc) ? w2 : w;
        end else pos++;
        act = (pos <= cw);
      end
      exp_q.push_back({tk, bc, act ? pol : !pol});
      tag_q.push_back(req);
    end
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back({1'b0, 1'b0, !pol});
      tag_q.push_back({req, " R10"});
    end
    for (int c = 0; c < n; c++) begin
      if (c == 0) gen_en = 1;
      if (c == fd) frame_en = 1;
      if (c == cc) begin
        per_val = FW'(p2); wid_val = FW'(w2); div_val = DW'(d2);
      end
      @(negedge clk);
    end
    gen_en = 0; frame_en = 0;
    repeat (3) @(negedge clk);
    wait (exp_q.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {bit_stb, bclk, fsync}, 3'b000);
    sync_act_hi = 0;
    #1 check("R1 R9", {bit_stb, bclk, fsync}, 3'b001);
    sync_act_hi = 1;
    @(negedge clk);
    rst_n = 1;
    run_case("R2 R5 R6 R9", 3, 3, 7, 3, 7, 3, 1000, 0, 1'b1, 80);
    run_case("R3 R9 stereo", 0, 0, 31, 15, 31, 15, 1000, 0, 1'b0, 80);
    run_case("R6 R7 pulse", 1, 1, 3, 0, 3, 0, 1000, 10, 1'b1, 60);
    run_case("R4 R8 change", 2, 0, 5, 1, 2, 0, 20, 0, 1'b1, 90);
    run_case("R6 wide", 1, 1, 2, 5, 2, 5, 1000, 0, 1'b1, 30);
    run_case("R2 R7 late", 4, 4, 3, 1, 3, 1, 1000, 23, 1'b0, 75);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog R2 actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule